// File: doc/BRIEF.md
# Port Change-Detect Interrupt Unit

This unit watches an input port of parameterised width, eight bits by default, and raises an interrupt when the level of any selected bit differs from a stored copy of the port. The copy is refreshed whenever software reads or writes the port. It is not an edge detector. A bit that changes and stays changed keeps the interrupt condition alive until software accesses the port again. Each bit has its own change-enable bit, written through a simple strobe-and-data pair.

The interrupt flag is sticky. Clearing it only works once the mismatch has been ended by a port access, because the flag is set again on every cycle in which an enabled mismatch exists. The same flag is presented as a wake-from-sleep request. A power-on reset clears the enables, the stored copy and the flag. A second reset input, used for the external reset pin and for brown-out, clears only the flag. The stored copy and the enables survive that reset, so a change that happened around such a reset is still reported once the reset ends.

Top module: `pinchg_unit`

## Requirements
- R1: Bit i of `enData`, loaded when `enWr` is high at a clock edge, enables change detection on `pinLevel[i]`; a disabled bit never causes `irqFlag` to rise.
- R2: After power-on reset (`porRstN` low), all enables are 0, the stored copy is all zeros and `irqFlag` is 0; pin changes alone then raise no flag.
- R3: When an enabled bit of `pinLevel` differs from the stored copy in a cycle with no port access, `irqFlag` is 1 after the next rising clock edge.
- R4: A cycle with `portRd` or `portWr` high loads the current `pinLevel` into the stored copy at the clock edge, which ends any mismatch.
- R5: A pin change in the same cycle as a port access is absorbed into the stored copy, and no flag is raised for it.
- R6: `irqFlag` stays 1 until a `flagClr` strobe; a `flagClr` in a cycle with an enabled mismatch leaves the flag at 1.
- R7: `sysRstN` low clears `irqFlag` but keeps the stored copy and the enables; once it is released, a pin level that still differs from the stored copy raises the flag on the next edge.
- R8: `wakeReq` equals `irqFlag` at all times.
- R9: A `flagClr` strobe with no enabled mismatch makes `irqFlag` 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low; clears all state |
| sysRstN | input | 1 | Pin or brown-out reset, asynchronous, active low; clears the flag only |
| pinLevel | input | WIDTH | Synchronised port pin levels |
| enWr | input | 1 | Write strobe for the change-enable register |
| enData | input | WIDTH | New change-enable value |
| portRd | input | 1 | Port read strobe; refreshes the stored copy |
| portWr | input | 1 | Port write strobe; refreshes the stored copy |
| flagClr | input | 1 | Software clear of the interrupt flag |
| irqFlag | output | 1 | Sticky change interrupt flag |
| wakeReq | output | 1 | Wake-from-sleep request |

## Verification
The assertions assume that `pinLevel` is already synchronised, so it changes only between clock edges. They also assume that the port strobes are not raised while `sysRstN` is low, because the processor that issues them is held in reset at that time. Both resets are assumed to be released away from a rising edge. The stimulus keeps within these limits by changing every input, including the resets, just after the falling clock edge and by never driving a port strobe during a reset. It compares the flag against the OR of the enabled bits of the old and new pin values XORed together, over a sweep of stored values, new values and enable masks.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic snapLoad;  // refresh the stored port copy this cycle
    logic enLoad;    // load the change-enable register this cycle
    logic cmpHold;   // suppress the compare result this cycle
  } pcStrobe_t;

endpackage

// File: rtl/pinchg_datapath.sv
module pinchg_datapath
  import pinchg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             porRstN,
  input  pcStrobe_t        strobe,
  input  logic [WIDTH-1:0] pinLevel,
  input  logic [WIDTH-1:0] enData,
  output logic             mismatchAny,
  output logic [WIDTH-1:0] snapVal
);

  logic [WIDTH-1:0] snapReg;
  logic [WIDTH-1:0] enReg;
  logic [WIDTH-1:0] bitHit;

  // Stored copy: only a power-on reset clears it.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      snapReg <= '0;
    end else if (strobe.snapLoad) begin
      snapReg <= pinLevel;
    end
  end

  // Change-enable register: only a power-on reset clears it.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      enReg <= '0;
    end else if (strobe.enLoad) begin
      enReg <= enData;
    end
  end

  // One compare slice per port bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign bitHit[i] = enReg[i] & (pinLevel[i] ^ snapReg[i]);
  end

  assign mismatchAny = (|bitHit) & ~strobe.cmpHold;
  assign snapVal     = snapReg;

endmodule

// File: rtl/pinchg_control.sv
module pinchg_control
  import pinchg_pkg::*;
(
  input  logic      clk,
  input  logic      porRstN,
  input  logic      sysRstN,
  input  logic      portRd,
  input  logic      portWr,
  input  logic      enWr,
  input  logic      flagClr,
  input  logic      mismatchAny,
  output pcStrobe_t strobe,
  output logic      irqFlag,
  output logic      wakeReq
);

  logic portAccess;
  logic flagReg;
  logic flagNext;

  assign portAccess      = portRd | portWr;
  assign strobe.snapLoad = portAccess;
  assign strobe.enLoad   = enWr;
  assign strobe.cmpHold  = portAccess;

  // Set has priority over clear: a live mismatch re-arms every cycle.
  assign flagNext = mismatchAny | (flagReg & ~flagClr);

  always_ff @(posedge clk or negedge porRstN or negedge sysRstN) begin
    if (!porRstN || !sysRstN) begin
      flagReg <= 1'b0;
    end else begin
      flagReg <= flagNext;
    end
  end

  assign irqFlag = flagReg;
  assign wakeReq = flagReg;

endmodule

// File: rtl/pinchg_unit.sv
module pinchg_unit
  import pinchg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             sysRstN,
  input  logic [WIDTH-1:0] pinLevel,
  input  logic             enWr,
  input  logic [WIDTH-1:0] enData,
  input  logic             portRd,
  input  logic             portWr,
  input  logic             flagClr,
  output logic             irqFlag,
  output logic             wakeReq
);

  pcStrobe_t        strobe;
  logic             mismatchAny;
  logic [WIDTH-1:0] snapVal;

  pinchg_control u_ctl (
    .clk        (clk),
    .porRstN    (porRstN),
    .sysRstN    (sysRstN),
    .portRd     (portRd),
    .portWr     (portWr),
    .enWr       (enWr),
    .flagClr    (flagClr),
    .mismatchAny(mismatchAny),
    .strobe     (strobe),
    .irqFlag    (irqFlag),
    .wakeReq    (wakeReq)
  );

  pinchg_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .porRstN    (porRstN),
    .strobe     (strobe),
    .pinLevel   (pinLevel),
    .enData     (enData),
    .mismatchAny(mismatchAny),
    .snapVal    (snapVal)
  );

endmodule

// File: rtl/pinchg_checker.sv
module pinchg_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             porRstN,
  input logic             sysRstN,
  input logic [WIDTH-1:0] pinLevel,
  input logic             portRd,
  input logic             portWr,
  input logic             flagClr,
  input logic [WIDTH-1:0] snapVal,
  input logic             mismatchAny,
  input logic             irqFlag
);

  // R3: a live mismatch always sets the flag on the next edge
  assert_mismatch_sets_R3: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    mismatchAny |=> irqFlag);

  // R1/R3: the flag only rises after an enabled mismatch
  assert_rise_has_cause_R3: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    $rose(irqFlag) |-> $past(mismatchAny));

  // R6: the flag holds without a clear strobe
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (irqFlag && !flagClr) |=> irqFlag);

  // R6: a clear that meets a mismatch does not win
  assert_clear_blocked_R6: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (flagClr && mismatchAny) |=> irqFlag);

  // R4: a port access loads the current levels
  assert_snap_load_R4: assert property (@(posedge clk) disable iff (!porRstN)
    (portRd || portWr) |=> (snapVal == $past(pinLevel)));

  // R7: without an access the copy holds, also across the system reset
  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!porRstN)
    !(portRd || portWr) |=> $stable(snapVal));

  // R5: a cycle with a port access never feeds the flag
  assert_access_masks_R5: assert property (@(posedge clk) disable iff (!porRstN)
    (portRd || portWr) |-> !mismatchAny);

endmodule

bind pinchg_unit pinchg_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .porRstN    (porRstN),
  .sysRstN    (sysRstN),
  .pinLevel   (pinLevel),
  .portRd     (portRd),
  .portWr     (portWr),
  .flagClr    (flagClr),
  .snapVal    (snapVal),
  .mismatchAny(mismatchAny),
  .irqFlag    (irqFlag)
);

// File: tb/sim_pinchg_unit.sv
`timescale 1ns/1ps
module sim_pinchg_unit;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         porRstN = 1'b0;
  logic         sysRstN = 1'b1;
  logic [W-1:0] pinLevel = '0;
  logic         enWr = 1'b0;
  logic [W-1:0] enData = '0;
  logic         portRd = 1'b0;
  logic         portWr = 1'b0;
  logic         flagClr = 1'b0;
  logic         irqFlag;
  logic         wakeReq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  pinchg_unit #(.WIDTH(W)) u0 (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .pinLevel(pinLevel),
    .enWr(enWr), .enData(enData), .portRd(portRd), .portWr(portWr),
    .flagClr(flagClr), .irqFlag(irqFlag), .wakeReq(wakeReq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle();
    enWr = 0; portRd = 0; portWr = 0; flagClr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] enList [5];
    enList[0] = 8'hFF; enList[1] = 8'h0F; enList[2] = 8'hA5;
    enList[3] = 8'h00; enList[4] = 8'h10;

    // R2: reset state
    repeat (2) tick();
    porRstN = 1;
    tick();
    check("R2 flag after power-on", irqFlag, 1'b0);
    check("R8 wake after power-on", wakeReq, 1'b0);
    pinLevel = 8'h5A; tick(); tick();
    check("R2 enables cleared", irqFlag, 1'b0);

    // R2: stored copy is zero after power-on: enable without access
    enWr = 1; enData = 8'hFF; tick(); idle(); tick();
    check("R2 copy zero after power-on", irqFlag, 1'b1);
    portRd = 1; flagClr = 1; tick(); idle(); tick();
    check("R4 access then clear", irqFlag, 1'b0);

    // R1 R3 R6 R8 R9 R4: sweep stored value, new value, enable mask
    for (int e = 0; e < 5; e++) begin
      for (int a = 0; a < 256; a += 37) begin
        for (int b = 0; b < 256; b += 29) begin
          logic expv;
          expv = |((a[W-1:0] ^ b[W-1:0]) & enList[e]);
          pinLevel = a[W-1:0]; enWr = 1; enData = enList[e];
          portRd = 1; flagClr = 1;
          tick();
          idle(); pinLevel = b[W-1:0];
          tick();
          check("R1 R3 flag from enabled mismatch", irqFlag, expv);
          check("R8 wake follows flag", wakeReq, expv);
          if (expv) begin
            flagClr = 1; tick(); idle();
            check("R6 clear blocked by mismatch", irqFlag, 1'b1);
            tick();
            check("R6 sticky without clear", irqFlag, 1'b1);
            portWr = 1; flagClr = 1; tick(); idle(); tick();
            check("R4 write ends mismatch", irqFlag, 1'b0);
          end else begin
            tick();
            check("R1 no flag on masked change", irqFlag, 1'b0);
          end
        end
      end
    end

    // R9: restore pins to stored value, clear with no mismatch
    enWr = 1; enData = 8'hFF; pinLevel = 8'h33; portRd = 1; flagClr = 1; tick();
    idle(); pinLevel = 8'h37; tick();
    check("R3 flag set", irqFlag, 1'b1);
    pinLevel = 8'h33; tick();
    check("R6 holds after mismatch ends", irqFlag, 1'b1);
    flagClr = 1; tick(); idle();
    check("R9 clear without mismatch", irqFlag, 1'b0);

    // R5: pin change in the same cycle as an access
    pinLevel = 8'hC3; portWr = 1; tick(); idle();
    check("R5 no flag for same-cycle change", irqFlag, 1'b0);
    tick();
    check("R5 change absorbed into copy", irqFlag, 1'b0);

    // R7: system reset keeps copy and enables
    pinLevel = 8'h0F; portRd = 1; tick(); idle(); tick();
    check("R7 baseline", irqFlag, 1'b0);
    pinLevel = 8'hF0; tick();
    check("R7 flag set before reset", irqFlag, 1'b1);
    sysRstN = 0; tick();
    check("R7 flag cleared in reset", irqFlag, 1'b0);
    tick();
    sysRstN = 1; tick();
    check("R7 copy and enables survive", irqFlag, 1'b1);
    check("R8 wake after system reset", wakeReq, 1'b1);

    // R2: power-on reset clears everything
    porRstN = 0; tick(); tick(); porRstN = 1; tick(); tick();
    check("R2 flag and enables cleared", irqFlag, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule